// File: doc/BRIEF.md
# Three-Phase Carrier PWM Gate Generator with Dead Time

This block turns three 6-bit modulation words into six gate lines for a three-phase bridge. Each phase has a high-side line and a low-side line. A symmetric triangular carrier runs for 252 system clocks per period. A phase's high side is commanded on while its word is greater than the carrier. The low side takes the complementary state. Every change of a leg between its two switches passes through a programmable dead gap during which both lines are off. The gap is 8 or 16 clocks.

A 2-bit drive-mode code selects the behaviour of the legs. In the off mode every leg is idle. In refresh mode only the bootstrap pulses are produced. Sine mode produces full complementary PWM. In square mode a high side is driven from the comparison while its low side floats, and a bootstrap pulse is forced on every low side near the bottom of each carrier period. Any of three conditions blocks all six lines at once: an overcurrent flag, a Hall-fault flag, or a low run input. The overcurrent block is latched until the next carrier bottom. A polarity input chooses active-high or active-low lines. A one-clock strobe marks the bottom of each carrier period.

Top module: `tri_phase_gate_pwm`

## Requirements
- R1: The carrier is a 6-bit triangle. Each carrier value is held for 2 clocks. It rises from 0 to 63 and then falls from 62 to 1, so one period is 252 clocks. `carrier_tick` is high for exactly one clock at each bottom, with carrier value 0, and the bottoms are 252 clocks apart.
- R2: When `drive_mode` = 2 (sine), a phase's high side is commanded on while its duty word is strictly greater than the carrier value, and the low side is commanded on otherwise. Over a period the high side is therefore commanded for 2·(2m−1) clocks for a word m ≥ 1, and for 0 clocks when m = 0.
- R3: Before either line of a leg turns on, both lines of that leg have been off for at least the dead gap. The gap is 8 clocks when `dt_short_sel` = 1 and 16 clocks when it is 0. The high and low lines of a leg are never on together.
- R4: When `act_high` = 1 an on line is driven 1. When `act_high` = 0 an on line is driven 0. This applies to all six lines, including the idle state.
- R5: A high `oc_flag` turns all six lines off from the next clock. The block stays latched until the carrier bottom that follows, even if the flag has dropped. After that bottom the lines resume.
- R6: While `run` is low, all six lines are held off and no bootstrap pulses are produced.
- R7: While `hall_bad` is high, all six lines are held off. Normal output resumes once the flag clears.
- R8: When `drive_mode` = 1 (refresh), every high side stays off. Every low side is on while the carrier is below 6, which is 22 clocks per period (about 8.7 %).
- R9: When `drive_mode` = 3 (square), a low side is commanded on only while the carrier is below 6. Outside that window the high side is commanded on while the word exceeds the carrier, and the leg floats otherwise. Per period this gives a high-side time of 4·(m−6) minus one gap and a low-side time of 22 minus one gap.
- R10: When `drive_mode` = 0 (off), all six lines are off.
- R11: During reset all six lines are off and `carrier_tick` is low. After reset, no line turns on before a full dead gap has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| duty_a | input | 6 | Modulation word, phase A |
| duty_b | input | 6 | Modulation word, phase B |
| duty_c | input | 6 | Modulation word, phase C |
| drive_mode | input | 2 | 0 off, 1 refresh, 2 sine, 3 square |
| dt_short_sel | input | 1 | 1: 8-clock gap, 0: 16-clock gap |
| act_high | input | 1 | Output polarity, 1 = active high |
| run | input | 1 | Low stops all outputs |
| oc_flag | input | 1 | Overcurrent detected |
| hall_bad | input | 1 | Position sensor state invalid |
| gate_hi_a | output | 1 | High-side line, phase A |
| gate_hi_b | output | 1 | High-side line, phase B |
| gate_hi_c | output | 1 | High-side line, phase C |
| gate_lo_a | output | 1 | Low-side line, phase A |
| gate_lo_b | output | 1 | Low-side line, phase B |
| gate_lo_c | output | 1 | Low-side line, phase C |
| carrier_tick | output | 1 | One-clock strobe at carrier bottom |

## Verification
A leg command formed from the carrier in one cycle shows at the lines on the next clock, because one leg register lies between the command and the polarity gate. A switch between sides adds the full dead gap to that. A blocking flag therefore darkens the lines exactly one clock after it is raised, and the bench samples at the falling edge that follows. For PWM results the bench avoids locating individual edges. It counts on-clocks over one whole period that begins at a strobe, and only after a whole period of settling. This makes every count independent of where in the period an input changed. The expected counts come from closed-form formulas for each mode and gap.

// File: rtl/gate_pwm_pkg.sv
package gate_pwm_pkg;

    typedef enum logic [1:0] {
        DRV_OFF     = 2'd0,
        DRV_REFRESH = 2'd1,
        DRV_SINE    = 2'd2,
        DRV_SQUARE  = 2'd3
    } drive_mode_e;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_state_e;

endpackage

// File: rtl/tri_carrier.sv
module tri_carrier #(
    parameter int CAR_W     = 6,
    parameter int STEP_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CAR_W-1:0] car_o,
    output logic             bottom_o,
    output logic             tick_o
);
    localparam int PRE_W = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CAR_W-1:0] TOP      = {CAR_W{1'b1}};
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(STEP_CLKS - 1);
    localparam int PERIOD  = 2 * STEP_CLKS * ((1 << CAR_W) - 1);
    localparam int PCHK_W  = $clog2(PERIOD + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CAR_W-1:0] car;
        logic             up;
        logic             tick;
    } car_st_t;

    car_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.pre == PRE_LAST) begin
            st_d.pre = '0;
            if (st_q.up) begin
                st_d.car = st_q.car + 1'b1;
                if (st_q.car == TOP - 1'b1) st_d.up = 1'b0;
            end else begin
                st_d.car = st_q.car - 1'b1;
                if (st_q.car == CAR_W'(1)) st_d.up = 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
        st_d.tick = (st_d.car == '0) && (st_d.pre == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pre  <= '0;
            st_q.car  <= '0;
            st_q.up   <= 1'b1;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign car_o    = st_q.car;
    assign bottom_o = (st_q.car == '0) && (st_q.pre == '0);
    assign tick_o   = st_q.tick;

    // checker state: clocks since the last strobe
    logic [PCHK_W-1:0] per_q;
    logic              seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick_o) begin
            per_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            per_q  <= per_q + 1'b1;
        end
    end

    p_tri_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.car) |-> ((st_q.car == $past(st_q.car) + 1'b1) ||
                                (st_q.car == $past(st_q.car) - 1'b1)));

    p_tick_bottom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (car_o == '0));

    p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && seen_q) |-> (per_q == PCHK_W'(PERIOD - 1)));

endmodule

// File: rtl/dead_time_leg.sv
module dead_time_leg
    import gate_pwm_pkg::*;
#(
    parameter int GAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  leg_state_e       tgt_i,
    input  logic [GAP_W-1:0] dt_i,
    output logic             hi_o,
    output logic             lo_o
);
    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    typedef struct packed {
        leg_state_e       lvl;
        logic [GAP_W-1:0] gap;
    } leg_st_t;

    leg_st_t st_q, st_d;
    logic    gap_done;

    always_comb begin
        st_d     = st_q;
        gap_done = (st_q.gap >= (dt_i - 1'b1));
        if (st_q.lvl != LEG_OFF) begin
            if (tgt_i != st_q.lvl) begin
                st_d.lvl = LEG_OFF;
                st_d.gap = '0;
            end
        end else begin
            if ((tgt_i != LEG_OFF) && gap_done) begin
                st_d.lvl = tgt_i;
            end else if (st_q.gap != GAP_MAX) begin
                st_d.gap = st_q.gap + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lvl <= LEG_OFF;
            st_q.gap <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hi_o = (st_q.lvl == LEG_HIGH);
    assign lo_o = (st_q.lvl == LEG_LOW);

    // checker: consecutive clocks with both lines off
    logic [GAP_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                run_q <= '0;
        else if (hi_o || lo_o)     run_q <= '0;
        else if (run_q != GAP_MAX) run_q <= run_q + 1'b1;
    end

    p_no_shoot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o));

    p_dead_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_o) || $rose(lo_o)) |-> (run_q >= dt_i));

endmodule

// File: rtl/tri_phase_gate_pwm.sv
module tri_phase_gate_pwm
    import gate_pwm_pkg::*;
#(
    parameter int CAR_W     = 6,
    parameter int STEP_CLKS = 2,
    parameter int DT_SHORT  = 8,
    parameter int DT_LONG   = 16,
    parameter int REF_LVL   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAR_W-1:0] duty_a,
    input  logic [CAR_W-1:0] duty_b,
    input  logic [CAR_W-1:0] duty_c,
    input  logic [1:0]       drive_mode,
    input  logic             dt_short_sel,
    input  logic             act_high,
    input  logic             run,
    input  logic             oc_flag,
    input  logic             hall_bad,
    output logic             gate_hi_a,
    output logic             gate_hi_b,
    output logic             gate_hi_c,
    output logic             gate_lo_a,
    output logic             gate_lo_b,
    output logic             gate_lo_c,
    output logic             carrier_tick
);
    localparam int NPH   = 3;
    localparam int GAP_W = $clog2(DT_LONG + 1);
    localparam logic [GAP_W-1:0] GAP_S = GAP_W'(DT_SHORT);
    localparam logic [GAP_W-1:0] GAP_L = GAP_W'(DT_LONG);
    localparam logic [CAR_W-1:0] WIN   = CAR_W'(REF_LVL);

    logic [CAR_W-1:0] car;
    logic             bottom;
    logic [CAR_W-1:0] duty [NPH];
    logic [NPH-1:0]   on_hi, on_lo;
    logic [GAP_W-1:0] gap_sel;
    logic             block, in_win;
    drive_mode_e      mode;

    typedef struct packed {
        logic oc_hold;
    } top_st_t;

    top_st_t st_q, st_d;

    tri_carrier #(
        .CAR_W    (CAR_W),
        .STEP_CLKS(STEP_CLKS)
    ) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .car_o   (car),
        .bottom_o(bottom),
        .tick_o  (carrier_tick)
    );

    assign duty[0] = duty_a;
    assign duty[1] = duty_b;
    assign duty[2] = duty_c;
    assign mode    = drive_mode_e'(drive_mode);
    assign gap_sel = dt_short_sel ? GAP_S : GAP_L;
    assign in_win  = (car < WIN);

    always_comb begin
        st_d         = st_q;
        st_d.oc_hold = oc_flag | (st_q.oc_hold & ~bottom);
        block        = ~run | oc_flag | st_q.oc_hold | hall_bad | (mode == DRV_OFF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.oc_hold <= 1'b0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        leg_state_e tgt;
        logic       above;

        assign above = (duty[p] > car);

        always_comb begin
            tgt = LEG_OFF;
            if (!block) begin
                case (mode)
                    DRV_REFRESH: tgt = in_win ? LEG_LOW : LEG_OFF;
                    DRV_SINE:    tgt = above ? LEG_HIGH : LEG_LOW;
                    DRV_SQUARE:  tgt = in_win ? LEG_LOW : (above ? LEG_HIGH : LEG_OFF);
                    default:     tgt = LEG_OFF;
                endcase
            end
        end

        dead_time_leg #(
            .GAP_W(GAP_W)
        ) u_leg (
            .clk  (clk),
            .rst_n(rst_n),
            .tgt_i(tgt),
            .dt_i (gap_sel),
            .hi_o (on_hi[p]),
            .lo_o (on_lo[p])
        );
    end

    assign gate_hi_a = on_hi[0] ~^ act_high;
    assign gate_hi_b = on_hi[1] ~^ act_high;
    assign gate_hi_c = on_hi[2] ~^ act_high;
    assign gate_lo_a = on_lo[0] ~^ act_high;
    assign gate_lo_b = on_lo[1] ~^ act_high;
    assign gate_lo_c = on_lo[2] ~^ act_high;

    p_oc_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |=> ((on_hi == '0) && (on_lo == '0)));

    p_oc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oc_hold && !bottom) |=> st_q.oc_hold);

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ((on_hi == '0) && (on_lo == '0)));

    p_hall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hall_bad |=> ((on_hi == '0) && (on_lo == '0)));

    p_refresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRV_REFRESH) |=> (on_hi == '0));

    p_off_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == DRV_OFF) |=> ((on_hi == '0) && (on_lo == '0)));

endmodule

// File: tb/tri_phase_gate_pwm_test.sv
module tri_phase_gate_pwm_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] da = '0, db = '0, dc = '0;
    logic [1:0] mode = 2'd0;
    logic       dts = 1'b1, pol = 1'b1, run = 1'b1, oc = 1'b0, hall = 1'b0;
    logic       gh_a, gh_b, gh_c, gl_a, gl_b, gl_c, tick;

    int checks = 0;
    int fails  = 0;

    tri_phase_gate_pwm uut (
        .clk(clk), .rst_n(rst_n),
        .duty_a(da), .duty_b(db), .duty_c(dc),
        .drive_mode(mode), .dt_short_sel(dts), .act_high(pol),
        .run(run), .oc_flag(oc), .hall_bad(hall),
        .gate_hi_a(gh_a), .gate_hi_b(gh_b), .gate_hi_c(gh_c),
        .gate_lo_a(gl_a), .gate_lo_b(gl_b), .gate_lo_c(gl_c),
        .carrier_tick(tick)
    );

    always #4 clk = ~clk;

    // {mode, duty_a, duty_b, duty_c, dt_short_sel}
    localparam logic [20:0] VEC [0:6] = '{
        {2'd2, 6'd20, 6'd10, 6'd45, 1'b1},
        {2'd2, 6'd20, 6'd10, 6'd45, 1'b0},
        {2'd2, 6'd0,  6'd63, 6'd32, 1'b1},
        {2'd1, 6'd30, 6'd0,  6'd63, 1'b0},
        {2'd3, 6'd40, 6'd40, 6'd50, 1'b0},
        {2'd3, 6'd40, 6'd20, 6'd50, 1'b1},
        {2'd0, 6'd40, 6'd20, 6'd50, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit on_lvl(input logic s);
        return s == pol;
    endfunction

    function automatic void expect_leg(input int md, input int m, input int d,
                                       output int eu, output int el);
        int raw, rl;
        eu = 0; el = 0;
        case (md)
            1: begin eu = 0; el = 22; end
            2: begin
                raw = (m == 0) ? 0 : 2 * (2 * m - 1);
                rl  = 252 - raw;
                if (raw == 0)     begin eu = 0;       el = 252;     end
                else if (raw <= d) begin eu = 0;      el = 252 - d; end
                else if (rl <= d)  begin eu = 252 - d; el = 0;      end
                else              begin eu = raw - d; el = rl - d;  end
            end
            3: begin eu = 4 * (m - 6) - d; el = 22 - d; end
            default: begin eu = 0; el = 0; end
        endcase
    endfunction

    task automatic measure(output int hc [3], output int lc [3], output int ov);
        logic [2:0] h, l;
        for (int i = 0; i < 3; i++) begin hc[i] = 0; lc[i] = 0; end
        ov = 0;
        @(negedge clk);
        while (!tick) @(negedge clk);
        for (int k = 0; k < 252; k++) begin
            h = {on_lvl(gh_c), on_lvl(gh_b), on_lvl(gh_a)};
            l = {on_lvl(gl_c), on_lvl(gl_b), on_lvl(gl_a)};
            for (int i = 0; i < 3; i++) begin
                hc[i] += int'(h[i]);
                lc[i] += int'(l[i]);
                if (h[i] && l[i]) ov++;
            end
            @(negedge clk);
        end
    endtask

    function automatic int any_on();
        return int'(on_lvl(gh_a) | on_lvl(gh_b) | on_lvl(gh_c) |
                    on_lvl(gl_a) | on_lvl(gl_b) | on_lvl(gl_c));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int hc [3];
        int lc [3];
        int ov, eu, el, d, cnt, n;
        logic [5:0] w [3];
        string tag;

        // R11 and R4: reset state in both polarities
        repeat (3) @(negedge clk);
        check({gh_a, gh_b, gh_c, gl_a, gl_b, gl_c, tick} == 7'b0, "R11 reset idle",
              int'({gh_a, gh_b, gh_c, gl_a, gl_b, gl_c, tick}), 0);
        pol = 1'b0;
        @(negedge clk);
        check({gh_a, gh_b, gh_c, gl_a, gl_b, gl_c} == 6'h3f, "R4 R11 active-low idle",
              int'({gh_a, gh_b, gh_c, gl_a, gl_b, gl_c}), 63);
        pol = 1'b1;
        mode = 2'd2; da = 6'd20; db = 6'd20; dc = 6'd20; dts = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        // R11: nothing turns on inside the first gap
        cnt = 0;
        for (int k = 0; k < 8; k++) begin
            cnt += any_on();
            @(negedge clk);
        end
        check(cnt == 0, "R11 first gap after reset", cnt, 0);

        // R1: strobe spacing
        @(negedge clk);
        while (!tick) @(negedge clk);
        n = 0;
        @(negedge clk);
        while (!tick) begin n++; @(negedge clk); end
        check(n + 1 == 252, "R1 carrier period", n + 1, 252);

        // vector table
        for (int v = 0; v < 7; v++) begin
            {mode, w[0], w[1], w[2], dts} = VEC[v];
            da = w[0]; db = w[1]; dc = w[2];
            d = dts ? 8 : 16;
            case (mode)
                2'd0: tag = "R10 off";
                2'd1: tag = "R8 refresh";
                2'd2: tag = "R2 R3 sine";
                default: tag = "R9 R3 square";
            endcase
            measure(hc, lc, ov);
            measure(hc, lc, ov);
            for (int p = 0; p < 3; p++) begin
                expect_leg(int'(mode), int'(w[p]), d, eu, el);
                check(hc[p] == eu, {tag, " high"}, hc[p], eu);
                check(lc[p] == el, {tag, " low"}, lc[p], el);
            end
            check(ov == 0, "R3 no overlap", ov, 0);
        end

        // R4: active-low polarity gives the same on-times
        mode = 2'd2; da = 6'd20; db = 6'd10; dc = 6'd45; dts = 1'b1; pol = 1'b0;
        measure(hc, lc, ov);
        measure(hc, lc, ov);
        expect_leg(2, 20, 8, eu, el);
        check(hc[0] == eu, "R4 active-low high", hc[0], eu);
        check(lc[0] == el, "R4 active-low low", lc[0], el);
        pol = 1'b1;

        // R5: latched overcurrent until the next bottom
        da = 6'd63; db = 6'd63; dc = 6'd63;
        measure(hc, lc, ov);
        @(negedge clk);
        while (!tick) @(negedge clk);
        repeat (50) @(negedge clk);
        oc = 1'b1;
        @(negedge clk);
        oc = 1'b0;
        cnt = 0; n = 0;
        while (!tick) begin cnt += any_on(); n++; @(negedge clk); end
        cnt += any_on();
        check(cnt == 0, "R5 blocked until bottom", cnt, 0);
        check(n > 150, "R5 hold spans flag drop", n, 200);
        measure(hc, lc, ov);
        check(hc[0] > 0, "R5 resumes after bottom", hc[0], 1);

        // R6: run low blocks refresh pulses
        mode = 2'd1; run = 1'b0;
        measure(hc, lc, ov);
        measure(hc, lc, ov);
        check(lc[0] + lc[1] + lc[2] + hc[0] == 0, "R6 stopped", lc[0] + lc[1] + lc[2], 0);
        run = 1'b1;
        measure(hc, lc, ov);
        measure(hc, lc, ov);
        check(lc[1] == 22, "R6 restart refresh", lc[1], 22);

        // R7: Hall fault blocks, then releases
        mode = 2'd2; da = 6'd20; db = 6'd10; dc = 6'd45; dts = 1'b1; hall = 1'b1;
        measure(hc, lc, ov);
        measure(hc, lc, ov);
        check(hc[0] + lc[0] + hc[2] + lc[2] == 0, "R7 hall blocked", hc[0] + lc[0], 0);
        hall = 1'b0;
        measure(hc, lc, ov);
        measure(hc, lc, ov);
        expect_leg(2, 45, 8, eu, el);
        check(hc[2] == eu, "R7 hall released", hc[2], eu);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule